// File: doc/BRIEF.md
# Framed Serial Panel Register Writer

This block programs a display panel's configuration registers over a three-wire serial link made of an active-low chip select, a serial clock and a data line. A client offers one register write at a time on a valid/ready port, giving an 8-bit register index and a 16-bit value. The block turns each write into two 24-bit frames: an index frame, then a data frame. Each frame is framed by its own chip-select window.

Every frame starts with a fixed 6-bit device identifier, followed by a register-select flag, a read/write flag and a 16-bit payload. Bits are shifted out most significant first. The panel samples each bit on the rising edge of the serial clock. All timing on the link is counted in bit-halves, and one bit-half is `HALF_CYCLES` system clocks. The `busy` output stays high for the whole transfer, and the link rests with all three lines high.

Top module: `panel_reg_writer`

## Requirements
- R1: After reset, and in the cycle after reset is applied during a transfer, `panelCsN`, `panelSck` and `panelSda` are high, `busy` is low and `reqReady` is high.
- R2: A request is taken only on a clock edge where `reqValid` and `reqReady` are both high. A request offered while `busy` is high has no effect on the frames being sent and is never sent later.
- R3: Each frame is 24 bits long, sent most significant bit first and valid at each rising `panelSck` edge. Bits [23:18] carry the device ID 0x1D and bit [16] is 0 (write).
- R4: Each accepted request produces exactly two frames. In the first, bit [17] is 0 and bits [15:0] carry the index, zero-extended. In the second, bit [17] is 1 and bits [15:0] carry the value.
- R5: `panelCsN` falls while `panelSck` and `panelSda` are high. It stays low for one bit-half before the first falling edge of `panelSck`.
- R6: For each bit, `panelSck` is low for exactly one bit-half and then high for one bit-half. While `panelCsN` is low, `panelSda` changes only when `panelSck` falls.
- R7: One bit-half after the last rising edge of `panelSck`, `panelCsN` rises. `panelSda` returns high one bit-half after that. `panelSck` is high whenever `panelCsN` is high.
- R8: `busy` rises in the cycle after acceptance and stays high for exactly 2*(2*24+3)*`HALF_CYCLES` cycles.
- R9: Each chip-select low window contains exactly 24 rising edges of `panelSck`.
- R10: `reqReady` is high in the first cycle that `busy` is low, so a new request can follow the previous one with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Write request offered |
| reqReady | output | 1 | Block idle and able to take a request |
| reqIndex | input | INDEX_W | Register index for the index frame |
| reqValue | input | PAY_W | Value for the data frame |
| busy | output | 1 | Transfer in progress |
| panelCsN | output | 1 | Serial chip select, active low |
| panelSck | output | 1 | Serial clock; the panel samples on its rising edge |
| panelSda | output | 1 | Serial data |

## Verification
A wrong state in the sequencer shows up as a chip-select window that is too short or too long. It can also show up as a wrong count of rising clock edges, within the same frame, and a slave that decodes the pins sees it as a wrong frame when chip select rises. A divider fault changes the length of a clock-low run or of the setup gap, so it can be seen one bit-half after it happens. A shift-register or load fault corrupts the ID, the flag bits or the payload, and the frame compare reports it at the end of that frame. An error in the end sequence shows up as a wrong `busy` length or as a line that is not high once the transfer is over.

// File: rtl/spw_pkg.sv
package spw_pkg;

  localparam int ID_W = 6;
  localparam logic [ID_W-1:0] DEV_ID_DEFAULT = 6'h1D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_CSEND,
    ST_GAP
  } ctrlState_t;

  // strobes from sequencer to datapath, one cycle each
  typedef struct packed {
    logic capture;   // latch request, load index frame
    logic loadData;  // load data frame
    logic csLow;
    logic csHigh;
    logic sckLow;    // drop clock and present next bit
    logic sckHigh;
    logic sdaIdle;
  } strobe_t;

endpackage

// File: rtl/spw_ctrl.sv
module spw_ctrl
  import spw_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int FRAME_W     = 24
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  output logic    reqReady,
  output logic    busy,
  output strobe_t strb
);

  localparam int DIV_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYCLES - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  ctrlState_t state, stateNext;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic second, secondNext;
  logic tick;

  assign tick     = (divCnt == DIV_LAST);
  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stateNext  = state;
    bitNext    = bitCnt;
    secondNext = second;
    strb       = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strb.capture = 1'b1;
        strb.csLow   = 1'b1;
        secondNext   = 1'b0;
        stateNext    = ST_SETUP;
      end
      ST_SETUP: if (tick) begin
        strb.sckLow = 1'b1;
        bitNext     = '0;
        stateNext   = ST_LOW;
      end
      ST_LOW: if (tick) begin
        strb.sckHigh = 1'b1;
        stateNext    = ST_HIGH;
      end
      ST_HIGH: if (tick) begin
        if (bitCnt == LAST_BIT) begin
          strb.csHigh = 1'b1;
          stateNext   = ST_CSEND;
        end else begin
          strb.sckLow = 1'b1;
          bitNext     = bitCnt + 1'b1;
          stateNext   = ST_LOW;
        end
      end
      ST_CSEND: if (tick) begin
        strb.sdaIdle = 1'b1;
        stateNext    = ST_GAP;
      end
      ST_GAP: if (tick) begin
        if (!second) begin
          strb.loadData = 1'b1;
          strb.csLow    = 1'b1;
          secondNext    = 1'b1;
          stateNext     = ST_SETUP;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      second <= 1'b0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitNext;
      second <= secondNext;
    end
  end

  // bit-half divider, restarted at every acceptance
  always_ff @(posedge clk) begin
    if (rst || state == ST_IDLE) divCnt <= '0;
    else if (tick)               divCnt <= '0;
    else                         divCnt <= divCnt + 1'b1;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.sckLow, strb.sckHigh, strb.csHigh, strb.sdaIdle})); // R6
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= LAST_BIT); // R9
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    divCnt <= DIV_LAST); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(strb.sckLow || strb.sckHigh || strb.csHigh)); // R2

endmodule

// File: rtl/spw_datapath.sv
module spw_datapath
  import spw_pkg::*;
#(
  parameter int              INDEX_W = 8,
  parameter int              PAY_W   = 16,
  parameter logic [ID_W-1:0] DEV_ID  = DEV_ID_DEFAULT
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strb,
  input  logic [INDEX_W-1:0] reqIndex,
  input  logic [PAY_W-1:0]   reqValue,
  output logic               csN,
  output logic               sck,
  output logic               sda
);

  localparam int FRAME_W = ID_W + 2 + PAY_W;

  logic [FRAME_W-1:0] shReg;
  logic [PAY_W-1:0]   valReg;
  logic [PAY_W-1:0]   idxPad;

  always_comb begin
    idxPad                = '0;
    idxPad[INDEX_W-1:0]   = reqIndex;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg  <= '0;
      valReg <= '0;
    end else begin
      if (strb.capture) begin
        shReg  <= {DEV_ID, 1'b0, 1'b0, idxPad};
        valReg <= reqValue;
      end else if (strb.loadData) begin
        shReg  <= {DEV_ID, 1'b1, 1'b0, valReg};
      end else if (strb.sckLow) begin
        shReg  <= {shReg[FRAME_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csN <= 1'b1;
      sck <= 1'b1;
      sda <= 1'b1;
    end else begin
      if (strb.csLow)   csN <= 1'b0;
      if (strb.csHigh)  csN <= 1'b1;
      if (strb.sckLow) begin
        sck <= 1'b0;
        sda <= shReg[FRAME_W-1];
      end
      if (strb.sckHigh) sck <= 1'b1;
      if (strb.sdaIdle) sda <= 1'b1;
    end
  end

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    csN |-> sck); // R7
  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!csN && $past(csN) == 1'b0 && sck && $past(sck)) |-> $stable(sda)); // R6
  AST_CS_FALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(csN) |-> (sck && sda)); // R5

endmodule

// File: rtl/panel_reg_writer.sv
module panel_reg_writer
  import spw_pkg::*;
#(
  parameter int              HALF_CYCLES = 4,
  parameter int              INDEX_W     = 8,
  parameter int              PAY_W       = 16,
  parameter logic [ID_W-1:0] DEV_ID      = DEV_ID_DEFAULT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [INDEX_W-1:0] reqIndex,
  input  logic [PAY_W-1:0]   reqValue,
  output logic               busy,
  output logic               panelCsN,
  output logic               panelSck,
  output logic               panelSda
);

  localparam int FRAME_W = ID_W + 2 + PAY_W;

  strobe_t strb;

  spw_ctrl #(
    .HALF_CYCLES(HALF_CYCLES),
    .FRAME_W    (FRAME_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .busy    (busy),
    .strb    (strb)
  );

  spw_datapath #(
    .INDEX_W(INDEX_W),
    .PAY_W  (PAY_W),
    .DEV_ID (DEV_ID)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .reqIndex(reqIndex),
    .reqValue(reqValue),
    .csN     (panelCsN),
    .sck     (panelSck),
    .sda     (panelSda)
  );

endmodule

// File: tb/panel_reg_writer_bench.sv
module panel_reg_writer_bench;

  localparam int H       = 4;
  localparam int BUSY_N  = 2 * (2 * 24 + 3) * H;
  localparam int NVEC    = 6;
  // {index[7:0], value[15:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00_0000, 24'hFF_FFFF, 24'h09_4A54,
    24'h5A_A5A5, 24'h12_8000, 24'hA6_0F0E
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [7:0]  reqIndex = '0;
  logic [15:0] reqValue = '0;
  logic reqReady, busy, panelCsN, panelSck, panelSda;

  always #2.5 clk = ~clk;

  panel_reg_writer #(.HALF_CYCLES(H)) u_panel_reg_writer (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqIndex(reqIndex), .reqValue(reqValue), .busy(busy),
    .panelCsN(panelCsN), .panelSck(panelSck), .panelSda(panelSda)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- serial slave model ----------------
  logic [23:0] fData [64];
  int fRise [64];
  int fSetup[64];
  int fBad  [64];
  int fGap  [64];
  int frameTotal = 0;

  logic pCs = 1'b1, pSck = 1'b1, pSda = 1'b1;
  logic [23:0] shIn;
  int rises, setupCnt, lowRun, bad, gapCnt, setupLen;
  bit sawFall, inGap;

  always @(negedge clk) begin
    if (pCs && !panelCsN) begin
      shIn = '0; rises = 0; setupCnt = 0; lowRun = 0; bad = 0;
      sawFall = 0; inGap = 0; setupLen = -1;
    end
    if (!panelCsN) begin
      if (panelSck && !sawFall) setupCnt++;
      if (!panelSck) begin
        if (!sawFall) setupLen = setupCnt;
        sawFall = 1;
        lowRun++;
      end
      if (!pSck && panelSck) begin
        shIn = {shIn[22:0], panelSda};
        rises++;
        if (lowRun != H) bad++;
        lowRun = 0;
      end
      if (!pCs && pSck && panelSck && (pSda != panelSda)) bad++;
    end
    if (!pCs && panelCsN) begin
      fData[frameTotal & 63] = shIn;
      fRise[frameTotal & 63] = rises;
      fSetup[frameTotal & 63] = setupLen;
      fBad[frameTotal & 63] = bad;
      fGap[frameTotal & 63] = -1;
      frameTotal++;
      inGap = 1; gapCnt = 0;
    end else if (panelCsN && inGap) begin
      gapCnt++;
      if (panelSda && !pSda) begin
        fGap[(frameTotal - 1) & 63] = gapCnt;
        inGap = 0;
      end
    end
    pCs = panelCsN; pSck = panelSck; pSda = panelSda;
  end

  // ---------------- helpers ----------------
  task automatic checkIdle(input string req);
    chk(panelCsN && panelSck && panelSda, req, "lines high",
        {panelCsN, panelSck, panelSda}, 3'b111);
    chk(!busy && reqReady, req, "busy/ready idle", {busy, reqReady}, 2'b01);
  endtask

  task automatic doWrite(input logic [7:0] idx, input logic [15:0] val,
                         input int ignoreAt);
    int base, cnt;
    logic [23:0] e0, e1;
    base = frameTotal;
    e0 = {6'h1D, 2'b00, 8'h00, idx};
    e1 = {6'h1D, 2'b10, val};
    @(negedge clk);
    reqValid = 1'b1; reqIndex = idx; reqValue = val;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy, "R8", "busy after accept", busy, 1);
    cnt = 0;
    while (busy) begin
      cnt++;
      if (cnt == ignoreAt) begin
        // R2: offer a different request mid-transfer
        chk(!reqReady, "R2", "ready low while busy", reqReady, 0);
        reqValid = 1'b1; reqIndex = ~idx; reqValue = ~val;
      end
      if (cnt == ignoreAt + 1) reqValid = 1'b0;
      @(negedge clk);
    end
    chk(cnt == BUSY_N, "R8", "busy length", cnt, BUSY_N);
    chk(reqReady, "R10", "ready when busy falls", reqReady, 1);
    checkIdle("R7");
    chk(frameTotal - base == 2, "R4", "frame count", frameTotal - base, 2);
    chk(fData[base & 63] == e0, "R3", "index frame", fData[base & 63], e0);
    chk(fData[(base + 1) & 63] == e1, "R4", "data frame", fData[(base + 1) & 63], e1);
    for (int f = 0; f < 2; f++) begin
      int k;
      logic [23:0] ef;
      k = (base + f) & 63;
      ef = (f == 0) ? e0 : e1;
      chk(fRise[k] == 24, "R9", "rising edges", fRise[k], 24);
      chk(fSetup[k] == H, "R5", "cs setup", fSetup[k], H);
      chk(fBad[k] == 0, "R6", "bit timing faults", fBad[k], 0);
      if (!ef[0]) chk(fGap[k] == H, "R7", "cs to sda gap", fGap[k], H);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int base;
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R1");

    // vector table, back to back (R10)
    for (int v = 0; v < NVEC; v++)
      doWrite(VEC[v][23:16], VEC[v][15:0], -1);

    // R2: request during transfer is ignored and never sent
    doWrite(8'h3C, 16'h1234, 60);
    base = frameTotal;
    repeat (40) @(negedge clk);
    chk(frameTotal == base, "R2", "no extra frame", frameTotal - base, 0);
    chk(!busy, "R2", "stays idle", busy, 0);

    // R1: reset in the middle of a frame
    @(negedge clk);
    reqValid = 1'b1; reqIndex = 8'h77; reqValue = 16'hBEEF;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (30) @(negedge clk);
    chk(!panelCsN, "R1", "mid-frame cs low", panelCsN, 0);
    rst = 1'b1;
    @(negedge clk);
    checkIdle("R1");
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R1");

    // a full write after the aborted one works
    doWrite(8'h81, 16'h0F0E, -1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule